// File: doc/BRIEF.md
# Single-Bit Delta-Sigma Conversion Counter

This block is the digital side of a first-order, one-bit delta-sigma analog-to-digital converter. An external integrator and comparator sit outside the chip. The comparator bit enters through a synchroniser and is registered once per clock. That registered bit leaves the block as the feedback level, which steers the integrator up or down and closes the loop.

Inside the block, a free-running timebase divides time into measurement windows of 2^CNT_W clocks. A totalising counter adds up the clocks in each window during which the feedback bit was high. On the last clock of a window, the total plus the final sample is copied into a holding register, a one-cycle valid strobe is raised, and counting restarts on the very next sample. No sample is dropped or counted twice. The held count is proportional to the average input level and stays stable while the following window is accumulated.

Top module: `dsm_adc_core`

## Requirements
- R1: While rst_ni is low, fb_o, valid_o and result_o are all zero. After reset is released, result_o and valid_o stay zero until the first window completes.
- R2: fb_o equals the value cmp_i had at the clock edge SYNC_STAGES+1 edges earlier. That is three edges with the default two synchroniser stages, and fb_o is zero for the first edges after reset.
- R3: Counting rising edges from reset release, valid_o is high after edge k*2^CNT_W (k = 1, 2, ...) and low after every other edge.
- R4: The value loaded at a window's end equals the number of high fb_o levels seen at the 2^CNT_W consecutive edges ending with the loading edge.
- R5: result_o changes only on the edge that raises valid_o and holds its value at every other edge.
- R6: A window in which fb_o is high at every edge yields result_o = 2^CNT_W (result_o is CNT_W+1 bits wide) and does not wrap to zero.
- R7: With the bench's integrator model driven by a constant level x out of full scale FS, each result after two settling windows lies within 2*(SYNC_STAGES+1)+2 codes of x*2^CNT_W/FS.
- R8: valid_o is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Comparator output from the external integrator (asynchronous) |
| fb_o | output | 1 | Registered sample driving the integrator feedback |
| result_o | output | CNT_W+1 | Count of high samples in the last complete window |
| valid_o | output | 1 | One-cycle strobe on each result update |

## Verification
The bench builds the block with CNT_W = 6 and SYNC_STAGES = 2, so each window is 64 clocks and the loop latency is three edges. This makes full-scale and empty windows, many back-to-back window rollovers, random bit patterns and settled closed-loop conversions at several input levels affordable within a few thousand cycles. Every edge is compared against a reference model. The model delays a queue of driven comparator bits and sums the delayed bits over windows of exactly 64 edges.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int unsigned DSM_CNT_W       = 16;
  localparam int unsigned DSM_SYNC_STAGES = 2;

  // edges from comparator input to feedback output
  function automatic int unsigned dsm_loop_latency(input int unsigned stages);
    return stages + 1;
  endfunction
endpackage

// File: rtl/dsm_sync.sv
module dsm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsm_timebase.sv
module dsm_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic term_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // last clock of the window
  assign term_o = &cnt_q;
endmodule

// File: rtl/dsm_totaliser.sv
module dsm_totaliser #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             term_i,
  output logic [CNT_W:0]   result_o,
  output logic             valid_o
);
  localparam int unsigned RES_W = CNT_W + 1;

  logic [CNT_W-1:0] total_q;
  logic [RES_W-1:0] result_q;
  logic             valid_q;
  logic [RES_W-1:0] closing_sum;

  // one bit wider than the total: a full window of ones reaches 2^CNT_W
  assign closing_sum = {1'b0, total_q} + {{CNT_W{1'b0}}, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q  <= '0;
      result_q <= '0;
      valid_q  <= 1'b0;
    end else if (term_i) begin
      result_q <= closing_sum;
      total_q  <= '0;
      valid_q  <= 1'b1;
    end else begin
      total_q  <= total_q + {{(CNT_W-1){1'b0}}, bit_i};
      valid_q  <= 1'b0;
    end
  end

  assign result_o = result_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/dsm_adc_core.sv
module dsm_adc_core
  import dsm_pkg::*;
#(
  parameter int unsigned CNT_W       = DSM_CNT_W,
  parameter int unsigned SYNC_STAGES = DSM_SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_i,
  output logic             fb_o,
  output logic [CNT_W:0]   result_o,
  output logic             valid_o
);
  logic cmp_sync;
  logic fb_q;
  logic term;

  dsm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_sync)
  );

  // the sampling flop: its output is both feedback and count input
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fb_q <= 1'b0;
    else         fb_q <= cmp_sync;
  end

  dsm_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .term_o(term)
  );

  dsm_totaliser #(.CNT_W(CNT_W)) u_totaliser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (fb_q),
    .term_i  (term),
    .result_o(result_o),
    .valid_o (valid_o)
  );

  assign fb_o = fb_q;
endmodule

// File: rtl/dsm_adc_chk.sv
module dsm_adc_chk
  import dsm_pkg::*;
#(
  parameter int unsigned CNT_W       = DSM_CNT_W,
  parameter int unsigned SYNC_STAGES = DSM_SYNC_STAGES
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cmp_i,
  input logic           fb_o,
  input logic [CNT_W:0] result_o,
  input logic           valid_o
);
  localparam int unsigned LAT   = dsm_loop_latency(SYNC_STAGES);
  localparam int unsigned WIN   = 1 << CNT_W;
  localparam int unsigned CYC_W = $clog2(LAT + 1);
  localparam logic [CNT_W:0] FULL = (CNT_W+1)'(WIN);

  logic [CYC_W-1:0] cyc_q;
  logic [CNT_W:0]   gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cyc_q <= '0;
    else if (int'(cyc_q) != LAT) cyc_q <= cyc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gap_q <= '0;
    else if (valid_o) gap_q <= (CNT_W+1)'(1);
    else              gap_q <= gap_q + 1'b1;
  end

  AST_FB_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cyc_q) == LAT) |-> (fb_o == $past(cmp_i, LAT))); // R2

  AST_VALID_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (gap_q == FULL)); // R3

  AST_VALID_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_q == FULL) |-> valid_o); // R3

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o <= FULL); // R6

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R8
endmodule

bind dsm_adc_core dsm_adc_chk #(
  .CNT_W      (CNT_W),
  .SYNC_STAGES(SYNC_STAGES)
) u_dsm_adc_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cmp_i   (cmp_i),
  .fb_o    (fb_o),
  .result_o(result_o),
  .valid_o (valid_o)
);

// File: tb/tb_dsm_adc_core.sv
`timescale 1ns/1ps
module tb_dsm_adc_core;
  localparam int N   = 6;
  localparam int SS  = 2;
  localparam int WIN = 1 << N;
  localparam int LAT = SS + 1;
  localparam int FS  = 1000;
  localparam int TOL = 2 * LAT + 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmp_i = 1'b0;
  logic fb_o;
  logic valid_o;
  logic [N:0] result_o;

  always #4 clk_i = ~clk_i;

  dsm_adc_core #(.CNT_W(N), .SYNC_STAGES(SS)) dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmp_i   (cmp_i),
    .fb_o    (fb_o),
    .result_o(result_o),
    .valid_o (valid_o)
  );

  int    checks = 0;
  int    errors = 0;
  int    edge_n, acc, res_exp, win_cnt, lvl;
  logic  fb_exp, fb_prev, val_exp;
  logic  hist[$];
  string req_tag = "R4 result";
  bit    loop_chk = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    cmp_i  = 1'b0;
    repeat (3) begin
      @(negedge clk_i);
      chk(fb_o === 1'b0 && valid_o === 1'b0 && result_o === '0,
          "R1 reset state", int'(result_o), 0);
    end
    rst_ni = 1'b1;
    hist.delete();
    fb_exp = 1'b0; fb_prev = 1'b0; val_exp = 1'b0;
    acc = 0; res_exp = 0; edge_n = 0; win_cnt = 0;
  endtask

  // drive one comparator bit, advance the model one edge, compare at negedge
  task automatic step(input logic c);
    int target, diff;
    cmp_i = c;
    hist.push_back(c);
    if (hist.size() > LAT) void'(hist.pop_front());
    @(posedge clk_i);
    edge_n++;
    fb_prev = fb_exp;
    fb_exp  = (hist.size() == LAT) ? hist[0] : 1'b0;
    if (edge_n % WIN == 0) begin
      res_exp = acc + int'(fb_prev);
      val_exp = 1'b1;
      acc     = 0;
      win_cnt++;
    end else begin
      acc    += int'(fb_prev);
      val_exp = 1'b0;
    end
    @(negedge clk_i);
    chk(fb_o === fb_exp, "R2 fb_o", int'(fb_o), int'(fb_exp));
    chk(valid_o === val_exp, "R3 R8 valid_o", int'(valid_o), int'(val_exp));
    chk(result_o === (N+1)'(res_exp), req_tag, int'(result_o), res_exp);
    if (loop_chk && val_exp && win_cnt >= 3) begin
      target = lvl * WIN / FS;
      diff   = int'(result_o) - target;
      if (diff < 0) diff = -diff;
      chk(diff <= TOL, "R7 closed-loop result", int'(result_o), target);
    end
  endtask

  task automatic run_loop(input int x, input int wins);
    int integ;
    integ = 0;
    lvl   = x;
    loop_chk = 1'b1;
    repeat (wins * WIN) begin
      integ += x - (fb_o ? FS : 0);
      step(integ > 0);
    end
    loop_chk = 1'b0;
  endtask

  initial begin
    // R1 reset and quiet first window
    do_reset();
    req_tag = "R1 R5 result before first window";
    repeat (WIN - 1) step(1'b0);

    // R6 full-scale windows
    do_reset();
    req_tag = "R6 full-scale result";
    repeat (3 * WIN) step(1'b1);

    // empty windows after full ones: result must fall back to zero
    req_tag = "R4 R5 empty-window result";
    repeat (3 * WIN) step(1'b0);

    // R4 alternating and random patterns, with R5 hold in between
    do_reset();
    req_tag = "R4 R5 alternating result";
    for (int i = 0; i < 2 * WIN; i++) step(logic'(i % 2));
    req_tag = "R4 R5 random result";
    repeat (4 * WIN) step(logic'($urandom_range(0, 1)));
    req_tag = "R4 sparse result";
    repeat (2 * WIN) step(logic'($urandom_range(0, 7) == 0));

    // R7 closed loop against an integrator model
    req_tag = "R4 R7 loop result";
    do_reset(); run_loop(250, 6);
    do_reset(); run_loop(600, 6);
    do_reset(); run_loop(900, 6);
    do_reset(); run_loop(0, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", edge_n, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule